// File: doc/BRIEF.md
# System-Side Loopback Switch with Clock Routing

This block sits on one link, between the system-facing serial ports of a T1/E1/J1 framer and the framer core. In normal operation it passes the receive stream to the system and the system's transmit stream to the framer. Two loopback directions are available:

- **Remote direction.** The system's transmit data and signaling are turned back onto the receive outputs.
- **Local direction.** The receive data and signaling are fed into the transmit path in place of the system's stream.

The bit clock and frame pulse are routed along with the data. Which way they are routed depends on which side of the interface is the clock master.

A loopback request is honoured only when the interface configuration permits it. Both sides must be non-multiplexed, exactly one side must be clock master, and neither side may run T1/J1 framing at the E1 rate. A request in any other configuration is refused: the paths stay in normal operation and a sticky error flag is raised.

All mode and enable inputs are sampled only at a frame boundary, so a frame is never switched part-way through. The frame boundary is a high frame pulse on the side that the currently applied settings mark as master. When the transmit side is not the applied master, the receive-side frame pulse is used.

Top module: `sys_lb_switch`

## Requirements
- R1: After reset, every output equals its normal-path input (receive to system, system to transmit, each clock and frame pulse straight through), and both the error flag and the conflict flag are 0.
- R2: A configuration is allowed exactly when all of the following hold: both multiplex bits are 0, exactly one of the two master bits is 1, and both E1-rate bits are 0.
- R3: When a boundary arrives while a loopback is requested in a configuration that is not allowed, every path is left in normal operation and `err_o` goes to 1 from the next cycle on.
- R4: `err_o` stays 1 until a cycle with `err_clr_i` high clears it. If a new error is set in the same cycle as the clear, the flag stays 1.
- R5: With the remote direction applied, `rx_sd_o`/`rx_sig_o` carry `tx_sd_i`/`tx_sig_i`, while `tx_sd_o`/`tx_sig_o` still carry `tx_sd_i`/`tx_sig_i`.
- R6: With the local direction applied, `tx_sd_o`/`tx_sig_o` carry `rx_sd_i`/`rx_sig_i`, while `rx_sd_o`/`rx_sig_o` still carry `rx_sd_i`/`rx_sig_i`.
- R7: If both enables are set in an allowed configuration, only the remote direction is applied and `conflict_o` is 1. Otherwise `conflict_o` is 0.
- R8: With the remote direction applied, clock and frame pulse are routed according to the master side:
  - receive master: `rx_ck_o`/`rx_fp_o` take `tx_ck_i`/`tx_fp_i`;
  - transmit master: `tx_ck_o`/`tx_fp_o` take `rx_ck_i`/`rx_fp_i`.
- R9: With the local direction applied, clock and frame pulse are routed according to the master side:
  - receive master: `tx_ck_o`/`tx_fp_o` take `rx_ck_i`/`rx_fp_i`;
  - transmit master: `rx_ck_o`/`rx_fp_o` take `tx_ck_i`/`tx_fp_i`.
- R10: Changes to mode or enable inputs have no effect on any output until a clock edge at which the boundary frame pulse is high. The new setting shows from the cycle after that edge.
- R11: A boundary with both enables at 0 returns all paths to normal operation and clears `conflict_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_mux_i | input | 1 | Receive side in multiplexed mode |
| cfg_tx_mux_i | input | 1 | Transmit side in multiplexed mode |
| cfg_rx_master_i | input | 1 | Receive side is clock master |
| cfg_tx_master_i | input | 1 | Transmit side is clock master |
| cfg_rx_e1rate_i | input | 1 | Receive side runs T1/J1 at E1 rate |
| cfg_tx_e1rate_i | input | 1 | Transmit side runs T1/J1 at E1 rate |
| en_remote_i | input | 1 | Request remote-direction loopback |
| en_local_i | input | 1 | Request local-direction loopback |
| err_clr_i | input | 1 | Clears the sticky error flag |
| rx_sd_i | input | DATA_W | Receive data from framer |
| rx_sig_i | input | SIG_W | Receive signaling from framer |
| tx_sd_i | input | DATA_W | Transmit data from system |
| tx_sig_i | input | SIG_W | Transmit signaling from system |
| rx_ck_i | input | 1 | Receive-side bit clock in |
| rx_fp_i | input | 1 | Receive-side frame pulse in |
| tx_ck_i | input | 1 | Transmit-side bit clock in |
| tx_fp_i | input | 1 | Transmit-side frame pulse in |
| rx_sd_o | output | DATA_W | Receive data to system |
| rx_sig_o | output | SIG_W | Receive signaling to system |
| tx_sd_o | output | DATA_W | Transmit data to framer |
| tx_sig_o | output | SIG_W | Transmit signaling to framer |
| rx_ck_o | output | 1 | Receive-side bit clock out |
| rx_fp_o | output | 1 | Receive-side frame pulse out |
| tx_ck_o | output | 1 | Transmit-side bit clock out |
| tx_fp_o | output | 1 | Transmit-side frame pulse out |
| conflict_o | output | 1 | Both directions requested; remote applied |
| err_o | output | 1 | Sticky refused-request flag |

## Verification
The embedded assertions are checked on every cycle and cover the following:
- the applied state holds between boundaries;
- a refused request leaves no loop active and the error flag set;
- the error flag is sticky;
- a conflict only ever coexists with the remote direction;
- the untouched stream in each direction stays untouched.

Some behaviour is shown only by the bench's scenarios. Its sweep over all 64 mode combinations and all four enable pairs shows which configurations are accepted and where each clock and frame pulse lands for each master choice. The bench also shows that outputs ignore pending changes until the boundary, and that a set takes precedence over a clear in the same cycle.

// File: rtl/sys_lb_pkg.sv
package sys_lb_pkg;

  typedef struct packed {
    logic rx_mux;
    logic tx_mux;
    logic rx_master;
    logic tx_master;
    logic rx_e1rate;
    logic tx_e1rate;
  } lb_mode_t;

  typedef struct packed {
    logic remote_on;
    logic local_on;
    logic rx_master;
    logic tx_master;
    logic conflict;
  } lb_act_t;

endpackage

// File: rtl/lb_cfg_check.sv
module lb_cfg_check
  import sys_lb_pkg::*;
(
  input  lb_mode_t mode_i,
  output logic     allowed_o
);

  logic non_mux;
  logic one_master;
  logic native_rate;

  always_comb begin
    non_mux     = ~mode_i.rx_mux & ~mode_i.tx_mux;
    one_master  = mode_i.rx_master ^ mode_i.tx_master;
    native_rate = ~mode_i.rx_e1rate & ~mode_i.tx_e1rate;
    allowed_o   = non_mux & one_master & native_rate;
  end

endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import sys_lb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lb_mode_t mode_i,
  input  logic     allowed_i,
  input  logic     en_remote_i,
  input  logic     en_local_i,
  input  logic     err_clr_i,
  input  logic     rx_fp_i,
  input  logic     tx_fp_i,
  output lb_act_t  act_o,
  output logic     err_o
);

  lb_act_t act_q, act_d;
  logic    err_q, err_d;
  logic    bnd;
  logic    req;

  assign bnd = act_q.tx_master ? tx_fp_i : rx_fp_i;
  assign req = en_remote_i | en_local_i;

  // next state
  always_comb begin
    act_d = act_q;
    err_d = err_q;
    if (err_clr_i) err_d = 1'b0;
    if (bnd) begin
      act_d.rx_master = mode_i.rx_master;
      act_d.tx_master = mode_i.tx_master;
      if (allowed_i) begin
        act_d.remote_on = en_remote_i;
        act_d.local_on  = en_local_i & ~en_remote_i;
        act_d.conflict  = en_remote_i & en_local_i;
      end else begin
        act_d.remote_on = 1'b0;
        act_d.local_on  = 1'b0;
        act_d.conflict  = 1'b0;
        if (req) err_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (bnd) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign act_o = act_q;
  assign err_o = err_q;

  assert_hold_between_frames_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(act_q));

  assert_refused_stays_normal_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (bnd && req && !allowed_i) |=> (!act_q.remote_on && !act_q.local_on && err_q));

  assert_err_sticky_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr_i) |=> err_q);

  assert_conflict_means_remote_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    act_q.conflict |-> (act_q.remote_on && !act_q.local_on));

endmodule

// File: rtl/lb_route.sv
module lb_route
  import sys_lb_pkg::*;
#(
  parameter int DATA_W = 1,
  parameter int SIG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lb_act_t           act_i,
  input  logic [DATA_W-1:0] rx_sd_i,
  input  logic [SIG_W-1:0]  rx_sig_i,
  input  logic [DATA_W-1:0] tx_sd_i,
  input  logic [SIG_W-1:0]  tx_sig_i,
  input  logic              rx_ck_i,
  input  logic              rx_fp_i,
  input  logic              tx_ck_i,
  input  logic              tx_fp_i,
  output logic [DATA_W-1:0] rx_sd_o,
  output logic [SIG_W-1:0]  rx_sig_o,
  output logic [DATA_W-1:0] tx_sd_o,
  output logic [SIG_W-1:0]  tx_sig_o,
  output logic              rx_ck_o,
  output logic              rx_fp_o,
  output logic              tx_ck_o,
  output logic              tx_fp_o
);

  logic rx_timing_from_tx;
  logic tx_timing_from_rx;

  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    assign rx_sd_o[i] = act_i.remote_on ? tx_sd_i[i] : rx_sd_i[i];
    assign tx_sd_o[i] = act_i.local_on  ? rx_sd_i[i] : tx_sd_i[i];
  end

  for (genvar j = 0; j < SIG_W; j++) begin : g_sig
    assign rx_sig_o[j] = act_i.remote_on ? tx_sig_i[j] : rx_sig_i[j];
    assign tx_sig_o[j] = act_i.local_on  ? rx_sig_i[j] : tx_sig_i[j];
  end

  always_comb begin
    rx_timing_from_tx = (act_i.remote_on & act_i.rx_master) |
                        (act_i.local_on  & act_i.tx_master);
    tx_timing_from_rx = (act_i.remote_on & act_i.tx_master) |
                        (act_i.local_on  & act_i.rx_master);
    rx_ck_o = rx_timing_from_tx ? tx_ck_i : rx_ck_i;
    rx_fp_o = rx_timing_from_tx ? tx_fp_i : rx_fp_i;
    tx_ck_o = tx_timing_from_rx ? rx_ck_i : tx_ck_i;
    tx_fp_o = tx_timing_from_rx ? rx_fp_i : tx_fp_i;
  end

  assert_tx_untouched_remote_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    act_i.remote_on |-> (tx_sd_o == tx_sd_i && tx_sig_o == tx_sig_i));

  assert_rx_untouched_local_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    act_i.local_on |-> (rx_sd_o == rx_sd_i && rx_sig_o == rx_sig_i));

endmodule

// File: rtl/sys_lb_switch.sv
module sys_lb_switch
  import sys_lb_pkg::*;
#(
  parameter int DATA_W = 1,
  parameter int SIG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rx_mux_i,
  input  logic              cfg_tx_mux_i,
  input  logic              cfg_rx_master_i,
  input  logic              cfg_tx_master_i,
  input  logic              cfg_rx_e1rate_i,
  input  logic              cfg_tx_e1rate_i,
  input  logic              en_remote_i,
  input  logic              en_local_i,
  input  logic              err_clr_i,
  input  logic [DATA_W-1:0] rx_sd_i,
  input  logic [SIG_W-1:0]  rx_sig_i,
  input  logic [DATA_W-1:0] tx_sd_i,
  input  logic [SIG_W-1:0]  tx_sig_i,
  input  logic              rx_ck_i,
  input  logic              rx_fp_i,
  input  logic              tx_ck_i,
  input  logic              tx_fp_i,
  output logic [DATA_W-1:0] rx_sd_o,
  output logic [SIG_W-1:0]  rx_sig_o,
  output logic [DATA_W-1:0] tx_sd_o,
  output logic [SIG_W-1:0]  tx_sig_o,
  output logic              rx_ck_o,
  output logic              rx_fp_o,
  output logic              tx_ck_o,
  output logic              tx_fp_o,
  output logic              conflict_o,
  output logic              err_o
);

  logic     rst_meta_q;
  logic     rst_sync_n;
  lb_mode_t mode;
  logic     allowed;
  lb_act_t  act;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    mode.rx_mux    = cfg_rx_mux_i;
    mode.tx_mux    = cfg_tx_mux_i;
    mode.rx_master = cfg_rx_master_i;
    mode.tx_master = cfg_tx_master_i;
    mode.rx_e1rate = cfg_rx_e1rate_i;
    mode.tx_e1rate = cfg_tx_e1rate_i;
  end

  lb_cfg_check u_check (
    .mode_i    (mode),
    .allowed_o (allowed)
  );

  lb_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .mode_i      (mode),
    .allowed_i   (allowed),
    .en_remote_i (en_remote_i),
    .en_local_i  (en_local_i),
    .err_clr_i   (err_clr_i),
    .rx_fp_i     (rx_fp_i),
    .tx_fp_i     (tx_fp_i),
    .act_o       (act),
    .err_o       (err_o)
  );

  lb_route #(.DATA_W(DATA_W), .SIG_W(SIG_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .act_i    (act),
    .rx_sd_i  (rx_sd_i),
    .rx_sig_i (rx_sig_i),
    .tx_sd_i  (tx_sd_i),
    .tx_sig_i (tx_sig_i),
    .rx_ck_i  (rx_ck_i),
    .rx_fp_i  (rx_fp_i),
    .tx_ck_i  (tx_ck_i),
    .tx_fp_i  (tx_fp_i),
    .rx_sd_o  (rx_sd_o),
    .rx_sig_o (rx_sig_o),
    .tx_sd_o  (tx_sd_o),
    .tx_sig_o (tx_sig_o),
    .rx_ck_o  (rx_ck_o),
    .rx_fp_o  (rx_fp_o),
    .tx_ck_o  (tx_ck_o),
    .tx_fp_o  (tx_fp_o)
  );

  assign conflict_o = act.conflict;

endmodule

// File: tb/sys_lb_switch_tb.sv
module sys_lb_switch_tb;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 1;
  localparam int SIG_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_mux = 0, tx_mux = 0, rx_m = 0, tx_m = 0, rx_e = 0, tx_e = 0;
  logic en_r = 0, en_l = 0, clr = 0;
  logic [DATA_W-1:0] rx_sd = '0, tx_sd = '0;
  logic [SIG_W-1:0]  rx_sig = '0, tx_sig = '0;
  logic rx_ck = 0, rx_fp = 0, tx_ck = 0, tx_fp = 0;
  logic [DATA_W-1:0] rx_sd_o, tx_sd_o;
  logic [SIG_W-1:0]  rx_sig_o, tx_sig_o;
  logic rx_ck_o, rx_fp_o, tx_ck_o, tx_fp_o, conflict_o, err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sys_lb_switch #(.DATA_W(DATA_W), .SIG_W(SIG_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rx_mux_i(rx_mux), .cfg_tx_mux_i(tx_mux),
    .cfg_rx_master_i(rx_m), .cfg_tx_master_i(tx_m),
    .cfg_rx_e1rate_i(rx_e), .cfg_tx_e1rate_i(tx_e),
    .en_remote_i(en_r), .en_local_i(en_l), .err_clr_i(clr),
    .rx_sd_i(rx_sd), .rx_sig_i(rx_sig), .tx_sd_i(tx_sd), .tx_sig_i(tx_sig),
    .rx_ck_i(rx_ck), .rx_fp_i(rx_fp), .tx_ck_i(tx_ck), .tx_fp_i(tx_fp),
    .rx_sd_o(rx_sd_o), .rx_sig_o(rx_sig_o), .tx_sd_o(tx_sd_o), .tx_sig_o(tx_sig_o),
    .rx_ck_o(rx_ck_o), .rx_fp_o(rx_fp_o), .tx_ck_o(tx_ck_o), .tx_fp_o(tx_fp_o),
    .conflict_o(conflict_o), .err_o(err_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_normal(string req);
    check(req, {3'b0, rx_sd_o, rx_sig_o}, {3'b0, rx_sd, rx_sig});
    check(req, {3'b0, tx_sd_o, tx_sig_o}, {3'b0, tx_sd, tx_sig});
    check(req, {4'b0, rx_ck_o, rx_fp_o, tx_ck_o, tx_fp_o},
               {4'b0, rx_ck, rx_fp, tx_ck, tx_fp});
  endtask

  task automatic tick();
    @(negedge clk); rx_fp = 1; tx_fp = 1;
    @(negedge clk); rx_fp = 0; tx_fp = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    rx_sd = 1; rx_sig = 4'h5; tx_sig = 4'hA; rx_ck = 1; tx_fp = 0;
    #1;
    check_normal("R1");
    check("R1", {6'b0, err_o, conflict_o}, 8'h0);

    for (int c = 0; c < 256; c++) begin
      logic [7:0] cv;
      logic valid, req, ra, la, rx_from_tx, tx_from_rx;
      string tag;
      cv = c[7:0];
      // back to normal and clear error
      @(negedge clk); en_r = 0; en_l = 0;
      tick();
      @(negedge clk); clr = 1;
      @(negedge clk); clr = 0;
      #1;
      check("R4", {7'b0, err_o}, 8'h0);
      check("R11", {7'b0, conflict_o}, 8'h0);
      rx_sd = cv[0]; tx_sd = ~cv[0]; rx_sig = cv[3:0]; tx_sig = ~cv[3:0];
      rx_ck = 0; tx_ck = 1;
      #1;
      check_normal("R11");
      // request new setting, no boundary yet
      {en_l, en_r, tx_e, rx_e, tx_m, rx_m, tx_mux, rx_mux} = cv;
      @(negedge clk); #1;
      check_normal("R10");
      check("R10", {6'b0, err_o, conflict_o}, 8'h0);
      tick();
      valid = !cv[0] && !cv[1] && (cv[2] ^ cv[3]) && !cv[4] && !cv[5];
      req   = cv[6] | cv[7];
      ra    = valid & cv[6];
      la    = valid & cv[7] & ~cv[6];
      rx_from_tx = (ra & cv[2]) | (la & cv[3]);
      tx_from_rx = (ra & cv[3]) | (la & cv[2]);
      tag = ra ? "R5" : (la ? "R6" : (req ? "R3" : "R2"));
      #1;
      check(req && !valid ? "R3" : "R2", {7'b0, err_o}, {7'b0, req & ~valid});
      check("R7", {7'b0, conflict_o}, {7'b0, valid & cv[6] & cv[7]});
      for (int p = 0; p < 16; p++) begin
        logic [3:0] pv;
        pv = p[3:0];
        rx_sd = pv[0]; tx_sd = pv[1]; rx_sig = pv; tx_sig = ~pv ^ 4'h3;
        #1;
        check(tag, {7'b0, rx_sd_o}, {7'b0, ra ? tx_sd : rx_sd});
        check(tag, {4'b0, rx_sig_o}, {4'b0, ra ? tx_sig : rx_sig});
        check(tag, {7'b0, tx_sd_o}, {7'b0, la ? rx_sd : tx_sd});
        check(tag, {4'b0, tx_sig_o}, {4'b0, la ? rx_sig : tx_sig});
      end
      for (int k = 0; k < 16; k++) begin
        logic [3:0] kv;
        kv = k[3:0];
        @(negedge clk);
        rx_ck = kv[0]; rx_fp = kv[1]; tx_ck = kv[2]; tx_fp = kv[3];
        #1;
        check(ra ? "R8" : (la ? "R9" : "R2"),
              {4'b0, rx_ck_o, rx_fp_o, tx_ck_o, tx_fp_o},
              {4'b0, rx_from_tx ? tx_ck : rx_ck, rx_from_tx ? tx_fp : rx_fp,
                     tx_from_rx ? rx_ck : tx_ck, tx_from_rx ? rx_fp : tx_fp});
      end
      @(negedge clk); rx_fp = 0; tx_fp = 0;
    end

    // set wins over clear in the same cycle
    @(negedge clk);
    {en_l, en_r, tx_e, rx_e, tx_m, rx_m, tx_mux, rx_mux} = 8'b0100_0101;
    rx_fp = 1; tx_fp = 1; clr = 1;
    @(negedge clk); rx_fp = 0; tx_fp = 0; clr = 0;
    #1;
    check("R4", {7'b0, err_o}, 8'h1);
    check_normal("R3");
    @(negedge clk); #1;
    check("R4", {7'b0, err_o}, 8'h1);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    #1;
    check("R4", {7'b0, err_o}, 8'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule